// File: doc/BRIEF.md
# Serial Modem Command Sequencer

This block brings a serial Wi-Fi modem up from reset and then feeds it blocks of sensor data, without any processor. It walks a fixed series of ASCII command lines (modem reset, join network, open a TCP client connection, announce a data transfer) that are held inside the logic as byte constants. Each line is handed byte by byte to an external UART transmitter over a valid/ready byte interface. Between lines it watches the UART receive byte stream for the modem's acknowledgement.

Once the connection is open, the block reports the link as up and waits for a block request. Each request produces one send command carrying the payload length in decimal. After the modem's `>` prompt, exactly that many payload bytes pass straight from the data source to the transmitter. A missing reply is handled with a per-step timeout and a bounded number of re-sends. When the re-sends run out, the block raises an error flag and restarts the whole bring-up.

Top module: `wifi_at_seq`

## Requirements
- R1: During and right after reset, `link_up`, `err_flag` and `blk_done` are 0. The first line transmitted is the modem reset command `AT+RST`.
- R2: Bring-up transmits `AT+RST`, then `AT+JOIN=lab,pw42`, then `AT+OPEN=TCP,10.0.0.7,5000`, in that order. Each step waits for its acknowledgement before the next one starts.
- R3: Every command line ends with 0x0D then 0x0A. While `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change, so no byte is lost or repeated.
- R4: A step advances only after the bytes 0x4F ('O') and 0x4B ('K') arrive on consecutive `rx_valid` beats while the block waits. Any other byte between them cancels the match.
- R5: The acknowledgement of the open-connection command sets `link_up` to 1.
- R6: A `blk_req` pulse while the link is idle transmits `AT+SEND=<PAY_LEN in decimal ASCII>` and its line end. The payload starts only after a 0x3E ('>') byte is received. An "OK" received while the block waits for this prompt has no effect.
- R7: After the prompt, exactly PAY_LEN bytes pass from `pl_data` to `tx_data` in order, with `pl_ready` following `tx_ready`. After the last of them, `pl_ready` stays low.
- R8: An "OK" after the payload produces a one-cycle `blk_done` pulse, and the block returns to idle with `link_up` still 1.
- R9: Later blocks start directly with the send command, without repeating reset, join or connect.
- R10: If no matching reply arrives within TIMEOUT_CYC cycles after a command line, the same command is sent again. At most MAX_RETRY (3) re-sends are made for one step.
- R11: When the wait after the last re-send also expires, `err_flag` goes to 1, `link_up` goes to 0, and the block restarts with `AT+RST`.
- R12: `err_flag` stays 1 during the re-initialisation and clears when the link comes back up. `link_up` and `err_flag` are never 1 together.
- R13: A `blk_req` that arrives while the link is not idle is dropped and produces no send command later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_req | input | 1 | Request to transmit one payload block |
| pl_data | input | 8 | Payload byte from the sample source |
| pl_valid | input | 1 | Payload byte available |
| pl_ready | output | 1 | Payload byte taken this cycle |
| tx_data | output | 8 | Byte to the UART transmitter |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmitter accepts the byte |
| rx_data | input | 8 | Byte from the UART receiver |
| rx_valid | input | 1 | Receive byte valid for one cycle |
| link_up | output | 1 | Connection open, ready for blocks |
| err_flag | output | 1 | Retries exhausted, re-initialising |
| blk_done | output | 1 | One-cycle pulse when a block is acknowledged |

## Verification
The assertions check the following on every cycle:
- Command bytes are held stable under transmitter back-pressure.
- Payload is accepted only while the link is up.
- `blk_done` is a single-cycle pulse seen only with the link up.
- The link is lost only together with a raised error flag, and the two flags never overlap.

Only the directed scenarios can show the exact byte content and order of each command line and the decimal length field. They also show:
- The two-byte acknowledgement match, including a broken "O..K" sequence that must not advance.
- The prompt-versus-OK distinction.
- The exact payload count.
- The re-send spacing and the retry limit.
- The shortened sequence used for later blocks.

// File: rtl/wat_pkg.sv
`timescale 1ns/1ps
package wat_pkg;
    localparam int IDX_W = 6;

    localparam logic [7:0] CH_CR = 8'h0D;
    localparam logic [7:0] CH_LF = 8'h0A;
    localparam logic [7:0] CH_O  = 8'h4F;
    localparam logic [7:0] CH_K  = 8'h4B;
    localparam logic [7:0] CH_GT = 8'h3E;

    typedef enum logic [1:0] {STEP_RST, STEP_JOIN, STEP_OPEN, STEP_SEND} step_e;
    typedef enum logic [1:0] {ST_CMD, ST_WAIT, ST_PAY, ST_IDLE} state_e;

    // Command bodies as byte constants; the line end is appended by the ROM.
    localparam int RST_LEN  = 6;
    localparam int JOIN_LEN = 16;
    localparam int OPEN_LEN = 25;
    localparam int SEND_LEN = 8;
    localparam logic [8*RST_LEN-1:0]  RST_TXT  = "AT+RST";
    localparam logic [8*JOIN_LEN-1:0] JOIN_TXT = "AT+JOIN=lab,pw42";
    localparam logic [8*OPEN_LEN-1:0] OPEN_TXT = "AT+OPEN=TCP,10.0.0.7,5000";
    localparam logic [8*SEND_LEN-1:0] SEND_TXT = "AT+SEND=";
endpackage

// File: rtl/wat_cmd_rom.sv
`timescale 1ns/1ps
module wat_cmd_rom
    import wat_pkg::*;
#(
    parameter int PAY_LEN = 16
) (
    input  step_e            step,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       byte_o,
    output logic             last_o
);
    localparam int NDIG    = (PAY_LEN >= 100) ? 3 : ((PAY_LEN >= 10) ? 2 : 1);
    localparam int TOP_DIV = (NDIG == 3) ? 100 : ((NDIG == 2) ? 10 : 1);

    function automatic logic [7:0] digit_char(input int k);
        int dv;
        dv = (k == 0) ? TOP_DIV : ((k == 1) ? (TOP_DIV / 10) : 1);
        if (dv == 0) dv = 1;
        return 8'h30 + 8'((PAY_LEN / dv) % 10);
    endfunction

    int         body_len;
    int         pos;
    logic [7:0] body_byte;

    always_comb begin
        pos       = int'(idx);
        body_byte = 8'h00;
        case (step)
            STEP_RST: begin
                body_len = RST_LEN;
                if (pos < RST_LEN) body_byte = RST_TXT[8*(RST_LEN-1-pos) +: 8];
            end
            STEP_JOIN: begin
                body_len = JOIN_LEN;
                if (pos < JOIN_LEN) body_byte = JOIN_TXT[8*(JOIN_LEN-1-pos) +: 8];
            end
            STEP_OPEN: begin
                body_len = OPEN_LEN;
                if (pos < OPEN_LEN) body_byte = OPEN_TXT[8*(OPEN_LEN-1-pos) +: 8];
            end
            default: begin
                body_len = SEND_LEN + NDIG;
                if (pos < SEND_LEN) body_byte = SEND_TXT[8*(SEND_LEN-1-pos) +: 8];
                else if (pos < body_len) body_byte = digit_char(pos - SEND_LEN);
            end
        endcase
        if (pos < body_len)       byte_o = body_byte;
        else if (pos == body_len) byte_o = CH_CR;
        else                      byte_o = CH_LF;
        last_o = (pos == body_len + 1);
    end
endmodule

// File: rtl/wat_resp_match.sv
`timescale 1ns/1ps
module wat_resp_match
    import wat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [7:0] rx_data,
    input  logic       rx_valid,
    output logic       ok_hit,
    output logic       prompt_hit
);
    typedef struct packed {
        logic saw_o;
        logic ok;
        logic gt;
    } mstate_t;

    mstate_t m_d, m_q;

    always_comb begin
        m_d    = m_q;
        m_d.ok = 1'b0;
        m_d.gt = 1'b0;
        if (clr) begin
            m_d.saw_o = 1'b0;
        end else if (rx_valid) begin
            m_d.ok    = m_q.saw_o && (rx_data == CH_K);
            m_d.gt    = (rx_data == CH_GT);
            m_d.saw_o = (rx_data == CH_O);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign ok_hit     = m_q.ok;
    assign prompt_hit = m_q.gt;
endmodule

// File: rtl/wat_step_timer.sv
`timescale 1ns/1ps
module wat_step_timer #(
    parameter int TIMEOUT_CYC = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expired = run && (cnt_q == CW'(TIMEOUT_CYC - 1));

    always_comb begin
        if (!run || expired) cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wifi_at_seq.sv
`timescale 1ns/1ps
module wifi_at_seq
    import wat_pkg::*;
#(
    parameter int PAY_LEN     = 16,
    parameter int TIMEOUT_CYC = 50000,
    parameter int MAX_RETRY   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       blk_req,
    input  logic [7:0] pl_data,
    input  logic       pl_valid,
    output logic       pl_ready,
    output logic [7:0] tx_data,
    output logic       tx_valid,
    input  logic       tx_ready,
    input  logic [7:0] rx_data,
    input  logic       rx_valid,
    output logic       link_up,
    output logic       err_flag,
    output logic       blk_done
);
    localparam int PW = $clog2(PAY_LEN + 1);
    localparam int TW = $clog2(MAX_RETRY + 1);

    typedef struct packed {
        state_e           st;
        step_e            step;
        logic [IDX_W-1:0] idx;
        logic [TW-1:0]    tries;
        logic             data_phase;
        logic [PW-1:0]    pay_cnt;
        logic             link;
        logic             err;
        logic             done;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_CMD, step: STEP_RST, idx: '0, tries: '0,
                                 data_phase: 1'b0, pay_cnt: '0, link: 1'b0,
                                 err: 1'b0, done: 1'b0};

    ctl_t       c_d, c_q;
    logic [7:0] rom_byte;
    logic       rom_last;
    logic       ok_hit, prompt_hit, tmo;
    logic       cmd_active, pay_active, waiting, want_prompt;

    assign cmd_active  = (c_q.st == ST_CMD);
    assign pay_active  = (c_q.st == ST_PAY);
    assign waiting     = (c_q.st == ST_WAIT);
    assign want_prompt = (c_q.step == STEP_SEND) && !c_q.data_phase;

    wat_cmd_rom #(.PAY_LEN(PAY_LEN)) u_rom (
        .step   (c_q.step),
        .idx    (c_q.idx),
        .byte_o (rom_byte),
        .last_o (rom_last)
    );

    wat_resp_match u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (!waiting),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .ok_hit     (ok_hit),
        .prompt_hit (prompt_hit)
    );

    wat_step_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (waiting),
        .expired (tmo)
    );

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        case (c_q.st)
            ST_CMD: begin
                if (tx_ready) begin
                    if (rom_last) begin
                        c_d.st  = ST_WAIT;
                        c_d.idx = '0;
                    end else begin
                        c_d.idx = c_q.idx + 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (want_prompt && prompt_hit) begin
                    c_d.st      = ST_PAY;
                    c_d.pay_cnt = '0;
                end else if (!want_prompt && ok_hit) begin
                    c_d.tries = '0;
                    case (c_q.step)
                        STEP_RST:  begin c_d.step = STEP_JOIN; c_d.st = ST_CMD; end
                        STEP_JOIN: begin c_d.step = STEP_OPEN; c_d.st = ST_CMD; end
                        STEP_OPEN: begin
                            c_d.st   = ST_IDLE;
                            c_d.link = 1'b1;
                            c_d.err  = 1'b0;
                        end
                        default: begin
                            c_d.st         = ST_IDLE;
                            c_d.data_phase = 1'b0;
                            c_d.done       = 1'b1;
                        end
                    endcase
                end else if (tmo) begin
                    c_d.st         = ST_CMD;
                    c_d.idx        = '0;
                    c_d.data_phase = 1'b0;
                    if (c_q.tries == TW'(MAX_RETRY)) begin
                        c_d.tries = '0;
                        c_d.step  = STEP_RST;
                        c_d.link  = 1'b0;
                        c_d.err   = 1'b1;
                    end else begin
                        c_d.tries = c_q.tries + 1'b1;
                    end
                end
            end
            ST_PAY: begin
                if (pl_valid && tx_ready) begin
                    if (c_q.pay_cnt == PW'(PAY_LEN - 1)) begin
                        c_d.st         = ST_WAIT;
                        c_d.data_phase = 1'b1;
                    end else begin
                        c_d.pay_cnt = c_q.pay_cnt + 1'b1;
                    end
                end
            end
            default: begin
                if (blk_req) begin
                    c_d.st    = ST_CMD;
                    c_d.step  = STEP_SEND;
                    c_d.idx   = '0;
                    c_d.tries = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= CTL_RST;
        else        c_q <= c_d;
    end

    assign tx_valid = cmd_active || (pay_active && pl_valid);
    assign tx_data  = pay_active ? pl_data : rom_byte;
    assign pl_ready = pay_active && tx_ready;
    assign link_up  = c_q.link;
    assign err_flag = c_q.err;
    assign blk_done = c_q.done;
endmodule

// File: rtl/wat_seq_chk.sv
`timescale 1ns/1ps
module wat_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_cmd,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       pl_ready,
    input logic       link_up,
    input logic       err_flag,
    input logic       blk_done
);
    // R3
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_cmd && tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    // R7
    pay_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pl_ready |-> link_up);

    // R8
    done_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> link_up);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> !blk_done);

    // R11
    link_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_up) |-> err_flag);

    // R11
    err_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> in_cmd);

    // R12
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(link_up && err_flag));
endmodule

bind wifi_at_seq wat_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_cmd   (cmd_active),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .pl_ready (pl_ready),
    .link_up  (link_up),
    .err_flag (err_flag),
    .blk_done (blk_done)
);

// File: tb/wifi_at_seq_tb.sv
`timescale 1ns/1ps
module wifi_at_seq_tb;
    localparam int PAY = 12;
    localparam int TMO = 120;
    localparam int RETRY = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       blk_req = 1'b0;
    logic       pl_valid = 1'b0;
    logic       tx_ready = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic [7:0] pl_data;
    logic       pl_ready, tx_valid, link_up, err_flag, blk_done;
    logic [7:0] tx_data;

    int n_chk = 0;
    int n_bad = 0;
    int pl_cnt = 0;
    int cyc = 0;
    int txn = 0;
    int done_cnt = 0;
    logic ready_en = 1'b0;
    logic bp_mode = 1'b0;
    logic [7:0] txb [0:2047];
    int         txc [0:2047];

    assign pl_data = 8'hA0 + 8'(pl_cnt);

    wifi_at_seq #(.PAY_LEN(PAY), .TIMEOUT_CYC(TMO), .MAX_RETRY(RETRY)) u_dut (
        .clk(clk), .rst_n(rst_n), .blk_req(blk_req),
        .pl_data(pl_data), .pl_valid(pl_valid), .pl_ready(pl_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .link_up(link_up), .err_flag(err_flag), .blk_done(blk_done)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) if (pl_valid && pl_ready) pl_cnt <= pl_cnt + 1;
    always @(posedge clk) begin
        #1;
        tx_ready = ready_en && (!bp_mode || (cyc % 3 != 0));
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid && tx_ready && txn < 2048) begin
                txb[txn] = tx_data;
                txc[txn] = cyc;
                txn++;
            end
            if (blk_done) done_cnt++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_bytes(input string req, input int n);
        for (int i = 0; i < 3000 && txn < n; i++) @(negedge clk);
        chk(req, "transmitted byte count reached", (txn >= n) ? n : txn, n);
    endtask

    task automatic send_rx(input string s);
        for (int i = 0; i < s.len(); i++) begin
            @(posedge clk); #1;
            rx_valid = 1'b1;
            rx_data  = s[i];
        end
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic send_rx_crlf_ok();
        @(posedge clk); #1; rx_valid = 1'b1; rx_data = 8'h0D;
        @(posedge clk); #1; rx_data = 8'h0A;
        @(posedge clk); #1; rx_data = "O";
        @(posedge clk); #1; rx_data = "K";
        @(posedge clk); #1; rx_valid = 1'b0;
    endtask

    task automatic pulse_req();
        @(posedge clk); #1 blk_req = 1'b1;
        @(posedge clk); #1 blk_req = 1'b0;
    endtask

    task automatic expect_cmd(input string req, input string body, input int at);
        int n;
        int fa;
        int fe;
        logic [7:0] e;
        n  = body.len();
        fa = 0;
        fe = 0;
        wait_bytes(req, at + n + 2);
        for (int i = n + 1; i >= 0; i--) begin
            e = (i < n) ? body[i] : ((i == n) ? 8'h0D : 8'h0A);
            if (txb[at+i] !== e) begin
                fa = int'(txb[at+i]);
                fe = int'(e);
            end
        end
        chk(req, $sformatf("line '%s' + CR LF bytes", body), fa, fe);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(5);
        chk("R1", "link_up in reset", int'(link_up), 0);
        chk("R1", "err_flag in reset", int'(err_flag), 0);
        chk("R1", "blk_done in reset", int'(blk_done), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        ready_en = 1'b1;
        idle(2);
        chk("R1", "link_up after reset", int'(link_up), 0);
    endtask

    task automatic t_bringup();
        int s;
        int held;
        s = txn;
        expect_cmd("R1", "AT+RST", s);
        held = txn;
        idle(30);
        chk("R4", "no advance without reply", txn, held);
        send_rx("Ox");
        send_rx("K");
        idle(20);
        chk("R4", "broken O..K ignored", txn, held);
        send_rx("OK");
        expect_cmd("R2", "AT+JOIN=lab,pw42", s + 8);
        pulse_req();
        send_rx_crlf_ok();
        expect_cmd("R2", "AT+OPEN=TCP,10.0.0.7,5000", s + 26);
        chk("R5", "link down before open ack", int'(link_up), 0);
        send_rx("OK");
        idle(5);
        chk("R5", "link_up after open ack", int'(link_up), 1);
        held = txn;
        idle(25);
        chk("R13", "early blk_req dropped", txn, held);
    endtask

    task automatic t_block(input string req);
        int s;
        int p0;
        int d0;
        int fa;
        int fe;
        s  = txn;
        p0 = pl_cnt;
        d0 = done_cnt;
        pl_valid = 1'b1;
        pulse_req();
        expect_cmd(req, $sformatf("AT+SEND=%0d", PAY), s);
        send_rx("OK");
        idle(10);
        chk("R6", "OK before prompt starts no payload", pl_cnt - p0, 0);
        send_rx(">");
        wait_bytes("R7", s + 12 + PAY);
        idle(10);
        chk("R7", "payload byte count", pl_cnt - p0, PAY);
        chk("R7", "no extra transmit bytes", txn, s + 12 + PAY);
        fa = 0;
        fe = 0;
        for (int i = PAY - 1; i >= 0; i--) begin
            if (txb[s+12+i] !== 8'(8'hA0 + p0 + i)) begin
                fa = int'(txb[s+12+i]);
                fe = int'(8'(8'hA0 + p0 + i));
            end
        end
        chk("R7", "payload bytes in order", fa, fe);
        chk("R8", "no done before final ack", done_cnt - d0, 0);
        send_rx("OK");
        idle(5);
        chk("R8", "one blk_done pulse", done_cnt - d0, 1);
        chk("R8", "link stays up", int'(link_up), 1);
    endtask

    task automatic t_timeout();
        int s;
        int p0;
        int gap;
        string sc;
        s  = txn;
        p0 = pl_cnt;
        sc = $sformatf("AT+SEND=%0d", PAY);
        pulse_req();
        for (int k = 0; k <= RETRY; k++) expect_cmd("R10", sc, s + 12 * k);
        gap = txc[s+12] - txc[s+11];
        chk("R10", "re-send spacing", gap,
            (gap >= TMO && gap <= TMO + 4) ? gap : TMO + 2);
        expect_cmd("R11", "AT+RST", s + 12 * (RETRY + 1));
        chk("R11", "err_flag after retries", int'(err_flag), 1);
        chk("R11", "link_up after retries", int'(link_up), 0);
        chk("R10", "no payload without prompt", pl_cnt - p0, 0);
    endtask

    task automatic t_recover();
        int s;
        s = txn - 8;
        bp_mode = 1'b1;
        send_rx("OK");
        expect_cmd("R3", "AT+JOIN=lab,pw42", s + 8);
        chk("R12", "err_flag held during re-init", int'(err_flag), 1);
        send_rx("OK");
        expect_cmd("R3", "AT+OPEN=TCP,10.0.0.7,5000", s + 26);
        send_rx("OK");
        idle(5);
        chk("R12", "link_up after recovery", int'(link_up), 1);
        chk("R12", "err_flag cleared after recovery", int'(err_flag), 0);
        bp_mode = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_bringup();
        t_block("R6");
        t_block("R9");
        t_timeout();
        t_recover();
        t_block("R9");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule